// File: doc/BRIEF.md
# Receive DMA Ring Engine with Two Alternating Descriptor Sets

This block takes received Ethernet frames from a byte stream and places them in a ring of fixed-size buffer slots in memory. Every frame starts a new slot. The frame data lands after a 16-byte header area. Once the last byte is in, the engine writes a short header that records the stored length and the frame status. Two descriptor sets feed the engine. Each set holds a base address, a count of remaining slots and an armed state. The engine stays on one set until that set can take no more frames. It then moves to the other set, but only if software has armed it.

Software loads each set through a small word-addressed register port. The usual sequence writes a load command, then the base, then the slot count, then the arm command. A control word halts or runs the channel. An interrupt with two status flags reports stored frames and overruns. Software works out how many slots a set has used by subtracting the remaining count it reads back from 8. Frames that find no usable set are dropped and counted.

Top module: `rx_dma_ring`

## Requirements
- R1: Register words: address bit 3 clear selects a set. Bit 2 picks set 0 or 1, which is a byte offset of 0x10. Bits 1:0 pick the field: 0 command, 1 base, 2 remaining count. Writing command 0x9800 arms a set, and any other command value (0x1100, 0x0100, ...) disarms it. A command read returns 0x9800 when the set is armed and 0x1100 when it is not.
- R2: Writing a remaining count above 8 stores 8. The count reads back as written otherwise.
- R3: Byte k of a stored frame goes to slot_base+16+k, where slot_base = base + (8 - remaining)*0x800. The set's remaining count drops by one once the frame completes.
- R4: After the data, the engine writes length[7:0] at slot_base+0 and {trunc, flags[2:0], length[11:8]} at slot_base+2, with trunc in bit 7 and flags in bits 6:4. It writes nothing else for the frame, and in_ready_o stays low during these two header writes.
- R5: Bytes past 2032 are discarded. The length field then holds 2032 and the trunc bit is set.
- R6: At the start of a frame, the current set is used if it is armed and has slots left. Failing that, the other set is used if it qualifies, and it becomes the current set. Frames then keep going to the new set.
- R7: When neither set qualifies while the channel runs, the frame is dropped with no memory write. missed_o rises by one (saturating), status bit 0x2000 sets, and irq_o rises.
- R8: Each stored frame sets status bit 0x0100 and raises irq_o. A command write to either set clears that bit.
- R9: Control word at address 8 (bit 3 set): writing 0x8800 halts the channel and clears bits 0x2000 and 0x0100, and writing 0x0400 runs it. Status bit 0x0400 shows the channel is running. A halted channel drops frames with no write and leaves missed_o unchanged. After reset the channel is halted, the sets are disarmed with zero counts, missed_o is 0 and irq_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| in_valid_i | input | 1 | Frame byte valid |
| in_ready_o | output | 1 | Engine accepts a byte |
| in_data_i | input | 8 | Frame byte |
| in_last_i | input | 1 | Last byte of the frame |
| in_flags_i | input | 3 | Receive status flags, sampled with the last byte |
| mem_we_o | output | 1 | Memory byte write strobe |
| mem_addr_o | output | 32 | Memory byte address |
| mem_data_o | output | 8 | Memory byte data |
| irq_o | output | 1 | Interrupt: frame stored or overrun |
| missed_o | output | 8 | Dropped-frame count (saturating) |

## Verification
The bench walks the set selection through its hard cases. It fills set 0 until it runs out and checks that the next frame moves to set 1. It then disarms set 1 while set 0 is empty and checks that the frame is dropped. It also reloads set 0 while set 1 still has slots, and checks that the engine does not switch back early. A design that switched on every frame, or on the arm alone, would put a frame in the wrong slot. A design that wrote into an empty set would overwrite earlier frames, and the bench compares the whole memory footprint of each frame to catch this. A 2040-byte frame tests truncation: an off-by-one limit would spill into the next slot or give the wrong length. A frame sent while the channel is halted must leave both memory and the missed count untouched.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_DATA, ST_DROP, ST_HDR_LO, ST_HDR_ST} wr_state_e;
  localparam logic [15:0] CMD_ARM  = 16'h9800;
  localparam logic [15:0] CMD_OFF  = 16'h1100;
  localparam logic [15:0] CTL_HALT = 16'h8800;
  localparam logic [15:0] CTL_RUN  = 16'h0400;
  localparam int STS_ERR_BIT  = 13;
  localparam int STS_RUN_BIT  = 10;
  localparam int STS_DONE_BIT = 8;
  localparam int LEN_W = 12;  // header length field width
endpackage

// File: rtl/rx_set_regs.sv
module rx_set_regs
  import rxr_pkg::*;
#(
  parameter int SLOTS = 8,
  parameter int AW    = 32,
  localparam int CNT_W = $clog2(SLOTS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_we_i,
  input  logic             base_we_i,
  input  logic             cnt_we_i,
  input  logic [31:0]      wdata_i,
  input  logic             dec_i,
  output logic             armed_o,
  output logic [AW-1:0]    base_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic             armed_q;
  logic [AW-1:0]    base_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      base_q  <= '0;
      cnt_q   <= '0;
    end else begin
      if (cmd_we_i)  armed_q <= (wdata_i[15:0] == CMD_ARM);
      if (base_we_i) base_q  <= wdata_i[AW-1:0];
      if (cnt_we_i) begin
        if (wdata_i > 32'(SLOTS)) cnt_q <= CNT_W'(SLOTS);
        else                      cnt_q <= wdata_i[CNT_W-1:0];
      end else if (dec_i && cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign armed_o = armed_q;
  assign base_o  = base_q;
  assign cnt_o   = cnt_q;

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(SLOTS)); // R2
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !cnt_we_i && cnt_q != '0) |=> (cnt_q == CNT_W'($past(cnt_q) - 1'b1))); // R3
endmodule

// File: rtl/rx_frame_writer.sv
module rx_frame_writer
  import rxr_pkg::*;
#(
  parameter int SLOT_BYTES = 2048,
  parameter int HDR_BYTES  = 16,
  parameter int AW         = 32,
  localparam int MAX_DATA  = SLOT_BYTES - HDR_BYTES
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          enable_i,
  input  logic          cur_ok_i,
  input  logic          oth_ok_i,
  input  logic [AW-1:0] cur_base_i,
  input  logic [AW-1:0] oth_base_i,
  input  logic          in_valid_i,
  output logic          in_ready_o,
  input  logic [7:0]    in_data_i,
  input  logic          in_last_i,
  input  logic [2:0]    in_flags_i,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [7:0]    mem_data_o,
  output logic          switch_o,
  output logic          miss_o,
  output logic          frame_done_o
);
  wr_state_e        state_q, state_d;
  logic [LEN_W-1:0] idx_q, idx_d;
  logic             trunc_q, trunc_d;
  logic [2:0]       flags_q, flags_d;
  logic [AW-1:0]    slot_q, slot_d;
  logic             we_d;
  logic [AW-1:0]    addr_d;
  logic [7:0]       data_d;

  assign in_ready_o = (state_q == ST_IDLE) || (state_q == ST_DATA) || (state_q == ST_DROP);

  always_comb begin
    state_d = state_q;
    idx_d = idx_q;
    trunc_d = trunc_q;
    flags_d = flags_q;
    slot_d = slot_q;
    we_d = 1'b0;
    addr_d = '0;
    data_d = '0;
    switch_o = 1'b0;
    miss_o = 1'b0;
    frame_done_o = 1'b0;
    unique case (state_q)
      ST_IDLE: if (in_valid_i) begin
        if (enable_i && (cur_ok_i || oth_ok_i)) begin
          slot_d   = cur_ok_i ? cur_base_i : oth_base_i;
          switch_o = !cur_ok_i;
          we_d     = 1'b1;
          addr_d   = slot_d + AW'(HDR_BYTES);
          data_d   = in_data_i;
          idx_d    = LEN_W'(1);
          trunc_d  = 1'b0;
          flags_d  = in_flags_i;
          state_d  = in_last_i ? ST_HDR_LO : ST_DATA;
        end else begin
          miss_o  = enable_i;
          state_d = in_last_i ? ST_IDLE : ST_DROP;
        end
      end
      ST_DATA: if (in_valid_i) begin
        if (idx_q < LEN_W'(MAX_DATA)) begin
          we_d   = 1'b1;
          addr_d = slot_q + AW'(HDR_BYTES) + AW'(idx_q);
          data_d = in_data_i;
          idx_d  = idx_q + 1'b1;
        end else begin
          trunc_d = 1'b1;
        end
        if (in_last_i) begin
          flags_d = in_flags_i;
          state_d = ST_HDR_LO;
        end
      end
      ST_DROP: if (in_valid_i && in_last_i) state_d = ST_IDLE;
      ST_HDR_LO: begin
        we_d = 1'b1;
        addr_d = slot_q;
        data_d = idx_q[7:0];
        state_d = ST_HDR_ST;
      end
      ST_HDR_ST: begin
        we_d = 1'b1;
        addr_d = slot_q + AW'(2);
        data_d = {trunc_q, flags_q, idx_q[LEN_W-1:8]};
        frame_done_o = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q <= '0;
      trunc_q <= 1'b0;
      flags_q <= '0;
      slot_q <= '0;
      mem_we_o <= 1'b0;
      mem_addr_o <= '0;
      mem_data_o <= '0;
    end else begin
      state_q <= state_d;
      idx_q <= idx_d;
      trunc_q <= trunc_d;
      flags_q <= flags_d;
      slot_q <= slot_d;
      mem_we_o <= we_d;
      mem_addr_o <= addr_d;
      mem_data_o <= data_d;
    end
  end

  AST_DROP_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DROP) |=> !mem_we_o); // R7
  AST_HDR_LEN_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HDR_LO) |=> (mem_we_o && mem_addr_o == $past(slot_q) && !in_ready_o)); // R4
  AST_WRITE_IN_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> ((mem_addr_o - slot_q) < AW'(SLOT_BYTES))); // R5
endmodule

// File: rtl/rx_dma_ring.sv
module rx_dma_ring
  import rxr_pkg::*;
#(
  parameter int SLOTS      = 8,
  parameter int SLOT_BYTES = 2048,
  parameter int HDR_BYTES  = 16,
  parameter int AW         = 32,
  parameter int MISS_W     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [3:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [7:0]        in_data_i,
  input  logic              in_last_i,
  input  logic [2:0]        in_flags_i,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [7:0]        mem_data_o,
  output logic              irq_o,
  output logic [MISS_W-1:0] missed_o
);
  localparam int CNT_W   = $clog2(SLOTS + 1);
  localparam int SLOT_SH = $clog2(SLOT_BYTES);

  logic             armed [2];
  logic [AW-1:0]    base  [2];
  logic [CNT_W-1:0] cnt   [2];
  logic [AW-1:0]    slot_base [2];
  logic [1:0]       set_ok;
  logic             cur_q;
  logic             run_q, done_q, err_q;
  logic [MISS_W-1:0] missed_q;
  logic             sw, miss, fdone;
  logic [1:0]       cmd_we;

  wire set_sel = !reg_addr_i[3];
  wire ctl_we  = reg_we_i && reg_addr_i[3];
  wire halt    = ctl_we && reg_wdata_i[15:0] == CTL_HALT;

  for (genvar g = 0; g < 2; g++) begin : g_set
    logic [AW-1:0] used;
    assign cmd_we[g] = reg_we_i && set_sel && reg_addr_i[2] == g[0] && reg_addr_i[1:0] == 2'd0;
    rx_set_regs #(.SLOTS(SLOTS), .AW(AW)) u_set (
      .clk_i, .rst_ni,
      .cmd_we_i (cmd_we[g]),
      .base_we_i(reg_we_i && set_sel && reg_addr_i[2] == g[0] && reg_addr_i[1:0] == 2'd1),
      .cnt_we_i (reg_we_i && set_sel && reg_addr_i[2] == g[0] && reg_addr_i[1:0] == 2'd2),
      .wdata_i  (reg_wdata_i),
      .dec_i    (fdone && cur_q == g[0]),
      .armed_o  (armed[g]),
      .base_o   (base[g]),
      .cnt_o    (cnt[g])
    );
    assign used = AW'(SLOTS) - AW'(cnt[g]);
    assign slot_base[g] = base[g] + (used << SLOT_SH);
    assign set_ok[g] = armed[g] && cnt[g] != '0;
  end

  rx_frame_writer #(.SLOT_BYTES(SLOT_BYTES), .HDR_BYTES(HDR_BYTES), .AW(AW)) u_wr (
    .clk_i, .rst_ni,
    .enable_i    (run_q),
    .cur_ok_i    (set_ok[cur_q]),
    .oth_ok_i    (set_ok[!cur_q]),
    .cur_base_i  (slot_base[cur_q]),
    .oth_base_i  (slot_base[!cur_q]),
    .in_valid_i, .in_ready_o, .in_data_i, .in_last_i, .in_flags_i,
    .mem_we_o, .mem_addr_o, .mem_data_o,
    .switch_o    (sw),
    .miss_o      (miss),
    .frame_done_o(fdone)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= 1'b0;
      run_q <= 1'b0;
      done_q <= 1'b0;
      err_q <= 1'b0;
      missed_q <= '0;
    end else begin
      if (sw) cur_q <= !cur_q;
      if (halt) run_q <= 1'b0;
      else if (ctl_we && reg_wdata_i[15:0] == CTL_RUN) run_q <= 1'b1;
      if (fdone) done_q <= 1'b1;
      else if (halt || |cmd_we) done_q <= 1'b0;
      if (miss) err_q <= 1'b1;
      else if (halt) err_q <= 1'b0;
      if (miss && missed_q != '1) missed_q <= missed_q + 1'b1;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i[3]) begin
      reg_rdata_o[STS_ERR_BIT]  = err_q;
      reg_rdata_o[STS_RUN_BIT]  = run_q;
      reg_rdata_o[STS_DONE_BIT] = done_q;
    end else begin
      unique case (reg_addr_i[1:0])
        2'd0: reg_rdata_o = {16'h0, armed[reg_addr_i[2]] ? CMD_ARM : CMD_OFF};
        2'd1: reg_rdata_o = 32'(base[reg_addr_i[2]]);
        2'd2: reg_rdata_o = 32'(cnt[reg_addr_i[2]]);
        default: reg_rdata_o = '0;
      endcase
    end
  end

  assign irq_o = done_q | err_q;
  assign missed_o = missed_q;

  AST_MISS_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> missed_q >= $past(missed_q)); // R7
  AST_DONE_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fdone |=> irq_o); // R8
  AST_HALT_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> !miss); // R9
endmodule

// File: tb/tb_rx_dma_ring.sv
`timescale 1ns/1ps
module tb_rx_dma_ring;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic in_ready;
  logic [7:0] in_data = '0;
  logic [2:0] in_flags = '0;
  logic mem_we;
  logic [31:0] mem_addr;
  logic [7:0] mem_data;
  logic irq;
  logic [7:0] missed;

  int tests = 0, fails = 0;
  logic [7:0] mem [int unsigned];

  bit b_armed [2];
  int b_cnt [2];
  int unsigned b_base [2];
  int b_cur = 0;
  bit b_en = 0;
  int b_miss = 0;

  always #4 clk = ~clk;

  rx_dma_ring dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data), .in_last_i(in_last),
    .in_flags_i(in_flags), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_data_o(mem_data),
    .irq_o(irq), .missed_o(missed)
  );

  always @(posedge clk) if (mem_we) mem[mem_addr] = mem_data;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic cmd(int s, logic [31:0] v);
    wr({1'b0, s[0], 2'd0}, v);
    b_armed[s] = (v[15:0] == 16'h9800);
  endtask

  task automatic load(int s, int unsigned base);
    cmd(s, 32'h0100);
    wr({1'b0, s[0], 2'd1}, base);
    wr({1'b0, s[0], 2'd2}, 32'd8);
    cmd(s, 32'h9800);
    b_base[s] = base; b_cnt[s] = 8;
  endtask

  function automatic logic [7:0] pat(int k, logic [7:0] s);
    return 8'(k * 7) ^ s;
  endfunction

  task automatic frame(int len, logic [2:0] fl, string req);
    int tgt = -1;
    int stored, bad;
    int unsigned sb;
    logic [7:0] s = 8'($urandom);
    logic [31:0] v;
    mem.delete();
    if (b_en) begin
      if (b_armed[b_cur] && b_cnt[b_cur] > 0) tgt = b_cur;
      else if (b_armed[1-b_cur] && b_cnt[1-b_cur] > 0) begin b_cur = 1 - b_cur; tgt = b_cur; end
      else if (b_miss < 255) b_miss++;
    end
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = pat(k, s); in_last = (k == len - 1); in_flags = fl;
      while (!in_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    repeat (5) @(negedge clk);
    check({req, " R7 missed count"}, 32'(missed), 32'(b_miss));
    if (tgt < 0) begin
      check({req, " R7 no write on drop"}, mem.num(), 0);
    end else begin
      stored = (len > 2032) ? 2032 : len;
      sb = b_base[tgt] + (8 - b_cnt[tgt]) * 2048;
      check({req, " R4 write footprint"}, mem.num(), stored + 2);
      check({req, " R4 length low"}, mem.exists(sb) ? 32'(mem[sb]) : 32'hdead, 32'(stored & 8'hff));
      check({req, " R4/R5 status byte"}, mem.exists(sb + 2) ? 32'(mem[sb + 2]) : 32'hdead,
            {24'h0, (len > 2032), fl, 4'(stored >> 8)});
      bad = 0;
      for (int k = 0; k < stored; k++) begin
        if (!mem.exists(sb + 16 + k)) bad++;
        else if (mem[sb + 16 + k] !== pat(k, s)) bad++;
      end
      check({req, " R3 data placement"}, bad, 0);
      b_cnt[tgt]--;
      rd({1'b0, tgt[0], 2'd2}, v);
      check({req, " R3 remaining count"}, v, b_cnt[tgt]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9 reset state
    check("R9 reset irq", irq, 0);
    check("R9 reset missed", missed, 0);
    rd(4'd8, v); check("R9 reset status", v, 0);
    rd(4'd0, v); check("R1 reset cmd readback", v, 32'h1100);
    rd(4'd6, v); check("R9 reset count", v, 0);
    // R2 clamp
    wr(4'd2, 32'd15);
    rd(4'd2, v); check("R2 count clamp", v, 8);
    wr(4'd2, 32'd5);
    rd(4'd2, v); check("R2 count plain", v, 5);
    // R9 halted: frame dropped, nothing counted
    load(0, 32'h1000_0000);
    frame(10, 3'd1, "R9 halted frame");
    wr(4'd8, 32'h0400); b_en = 1;
    rd(4'd8, v); check("R9 run status", v, 32'h0400);
    rd(4'd0, v); check("R1 armed readback", v, 32'h9800);
    // first frame, R8 done
    frame(1, 3'd5, "R3 single byte");
    rd(4'd8, v); check("R8 done flag", v, 32'h0500);
    check("R8 irq on done", irq, 1);
    cmd(0, 32'h9800);
    check("R8 irq cleared by cmd", irq, 0);
    // exhaust set 0
    for (int i = 0; i < 7; i++) frame($urandom_range(1, 64), 3'($urandom), "R3 random set0");
    rd(4'd2, v); check("R3 set0 empty", v, 0);
    load(1, 32'h2000_0000);
    frame(20, 3'd2, "R6 switch to set1");
    // R1 disarm set1 -> no usable set
    cmd(1, 32'h1100);
    rd(4'd4, v); check("R1 disarm readback", v, 32'h1100);
    frame(12, 3'd0, "R7 overrun drop");
    rd(4'd8, v); check("R7 error flag", v, 32'h2400);
    check("R7 irq on overrun", irq, 1);
    // R9 halt clears flags, halted drop not counted
    wr(4'd8, 32'h8800); b_en = 0;
    rd(4'd8, v); check("R9 halt status", v, 0);
    check("R9 irq after halt", irq, 0);
    frame(9, 3'd3, "R9 halted drop");
    wr(4'd8, 32'h0400); b_en = 1;
    cmd(1, 32'h9800);
    // R5 truncation
    frame(2040, 3'd6, "R5 truncation");
    frame(2032, 3'd4, "R5 exact limit");
    // R6 stay on set1 after set0 reloaded
    load(0, 32'h3000_0000);
    for (int i = 0; i < 12; i++) frame($urandom_range(1, 80), 3'($urandom), "R6 random stay/switch");
    rd(4'd6, v); check("R6 set1 exhausted", v, 0);
    rd(4'd2, v); check("R6 set0 partly used", v, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule